// File: doc/BRIEF.md
# Segmented Ping-Pong Corner-Turn Controller

This block performs the corner turn of an FMCW radar chain, sitting between range processing and Doppler processing. Range samples enter one chirp at a time (one row of the matrix), in row-major order on a valid/ready stream. The block writes them to a two-bank external memory and later streams the same matrix back column by column: for each range bin it delivers every chirp in order, ready for the Doppler stage.

Each row is cut into segments of `SEG` samples, and segments of the same index from all chirps are stacked into one small tile. The write offset for chirp `r`, range bin `c` is `((c / SEG) * N_CHIRP + r) * SEG + (c % SEG)`. This costs extra page changes on the write side but keeps column-order reads inside a few pages. The writer owns one bank and the reader owns the other. Roles swap after each whole matrix, and only once the writer holds a complete new frame and the reader has drained the previous one. Whichever side is done first waits. The writer waits by dropping `in_ready`; the reader simply has no `out_valid`.

The writer state machine has two states. `WR_FILL` accepts samples and moves to `WR_FULL` on the last sample of the matrix. `WR_FULL` holds `in_ready` low and returns to `WR_FILL` on a swap. The reader state machine has three states. `RD_IDLE` owns no frame and moves to `RD_FETCH` on a swap. `RD_FETCH` issues one memory read and always moves to `RD_HOLD` next cycle. `RD_HOLD` presents the sample; when it is accepted, it goes back to `RD_FETCH`, or to `RD_IDLE` after the frame's final sample. A swap is the cycle in which the writer is in `WR_FULL` and the reader is in `RD_IDLE`.

Top module: `corner_turn_ctrl`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, and neither memory enable is asserted until `in_valid` is driven.
- R2: Each accepted input sample is written in the same cycle with `mem_wr_data` equal to `in_data`. The low address bits equal `((c/SEG)*N_CHIRP + r)*SEG + c%SEG`, where `r` is the chirp index and `c` is the range bin counted in arrival order.
- R3: In any cycle where both memory enables are high, the top address bit (the bank select) of the write and of the read differ.
- R4: Output samples appear in column-major order (range bin outer, chirp inner). Each read uses the same tiled offset as R2, and `out_data` carries the value that was written at that position.
- R5: The first frame after reset produces no output. `out_valid` first rises only after the entire first matrix has been accepted.
- R6: `out_last` is 1 on the sample with chirp index `N_CHIRP-1` of every column and 0 otherwise. `out_frame_end` is 1 only on the final sample of the matrix, where `out_last` is also 1.
- R7: Once the writer has completed frame k+1 while frame k is still being read, `in_ready` stays 0 until the reader finishes frame k. After a frame's final output is accepted, `out_valid` is 0 in the next cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_last` and `out_frame_end` hold their values.
- R9: Frame k (counting from 0 after reset) is written to bank k mod 2 and read from that same bank; bank select is the top address bit.
- R10: The memory returns read data one cycle after `mem_rd_en`. A read is issued only when no output sample is pending, and `out_valid` is 1 in the cycle after each read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept an input sample |
| in_data | input | DATA_W | Input sample, row-major |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Write address: bank bit, then tiled offset |
| mem_wr_data | output | DATA_W | Write data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Read address: bank bit, then tiled offset |
| mem_rd_data | input | DATA_W | Read data, one cycle after `mem_rd_en` |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | DATA_W | Output sample, column-major |
| out_last | output | 1 | Final chirp of the current column |
| out_frame_end | output | 1 | Final sample of the matrix |

## Verification
The assertions check on every cycle the properties that need no frame history. These are: bank separation whenever both memory ports are busy, a stable output under backpressure, `out_frame_end` implying `out_last`, the idle cycle after a frame ends, and a read always followed by a valid sample. Only the bench scenarios can show properties that depend on frame counts. These are the exact tiled write and read address sequences, the per-frame bank alternation, the column-major data order across several frames, the silent first frame, and the writer stall while a previous frame is still draining.

// File: rtl/ct_pkg.sv
package ct_pkg;
    typedef enum logic {
        WR_FILL = 1'b0,
        WR_FULL = 1'b1
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_FETCH = 2'd1,
        RD_HOLD  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/ct_writer.sv
module ct_writer
    import ct_pkg::*;
#(
    parameter int N_CHIRP = 64,
    parameter int N_RANGE = 256,
    parameter int SEG     = 16,
    localparam int ROW_W  = $clog2(N_CHIRP),
    localparam int SEG_W  = $clog2(N_RANGE / SEG),
    localparam int OFF_W  = $clog2(SEG),
    localparam int OFS_W  = ROW_W + SEG_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             swap,
    output logic             in_ready,
    output logic             full,
    output logic             wr_en,
    output logic [OFS_W-1:0] wr_ofs
);
    localparam int NSEG = N_RANGE / SEG;

    wr_state_e        state_q, state_d;
    logic [ROW_W-1:0] row_q;
    logic [SEG_W-1:0] seg_q;
    logic [OFF_W-1:0] off_q;
    logic             off_end, seg_end, row_end, accept;

    assign off_end = (off_q == OFF_W'(SEG - 1));
    assign seg_end = (seg_q == SEG_W'(NSEG - 1));
    assign row_end = (row_q == ROW_W'(N_CHIRP - 1));
    assign accept  = in_valid && in_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_FILL: if (accept && off_end && seg_end && row_end) state_d = WR_FULL;
            WR_FULL: if (swap) state_d = WR_FILL;
            default: state_d = WR_FILL;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_FILL;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        in_ready = (state_q == WR_FILL);
        full     = (state_q == WR_FULL);
        wr_en    = accept;
        wr_ofs   = {seg_q, row_q, off_q};
    end

    // row-major position counters: offset fastest, then segment, then chirp
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            seg_q <= '0;
            off_q <= '0;
        end else if (accept) begin
            if (off_end) begin
                off_q <= '0;
                if (seg_end) begin
                    seg_q <= '0;
                    row_q <= row_end ? '0 : row_q + 1'b1;
                end else begin
                    seg_q <= seg_q + 1'b1;
                end
            end else begin
                off_q <= off_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ct_reader.sv
module ct_reader
    import ct_pkg::*;
#(
    parameter int N_CHIRP = 64,
    parameter int N_RANGE = 256,
    parameter int SEG     = 16,
    localparam int ROW_W  = $clog2(N_CHIRP),
    localparam int SEG_W  = $clog2(N_RANGE / SEG),
    localparam int OFF_W  = $clog2(SEG),
    localparam int OFS_W  = ROW_W + SEG_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             out_ready,
    output logic             idle,
    output logic             rd_en,
    output logic [OFS_W-1:0] rd_ofs,
    output logic             out_valid,
    output logic             out_last,
    output logic             out_frame_end
);
    localparam int NSEG = N_RANGE / SEG;

    rd_state_e        state_q, state_d;
    logic [ROW_W-1:0] row_q;
    logic [SEG_W-1:0] seg_q;
    logic [OFF_W-1:0] off_q;
    logic             off_end, seg_end, row_end, col_done, mat_done, taken;

    assign off_end  = (off_q == OFF_W'(SEG - 1));
    assign seg_end  = (seg_q == SEG_W'(NSEG - 1));
    assign row_end  = (row_q == ROW_W'(N_CHIRP - 1));
    assign col_done = row_end;
    assign mat_done = row_end && off_end && seg_end;
    assign taken    = (state_q == RD_HOLD) && out_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (start) state_d = RD_FETCH;
            RD_FETCH: state_d = RD_HOLD;
            RD_HOLD:  if (out_ready) state_d = mat_done ? RD_IDLE : RD_FETCH;
            default:  state_d = RD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        idle          = (state_q == RD_IDLE);
        rd_en         = (state_q == RD_FETCH);
        rd_ofs        = {seg_q, row_q, off_q};
        out_valid     = (state_q == RD_HOLD);
        out_last      = out_valid && col_done;
        out_frame_end = out_valid && mat_done;
    end

    // column-major position counters: chirp fastest, then offset, then segment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            seg_q <= '0;
            off_q <= '0;
        end else if (taken) begin
            if (row_end) begin
                row_q <= '0;
                if (off_end) begin
                    off_q <= '0;
                    seg_q <= seg_end ? '0 : seg_q + 1'b1;
                end else begin
                    off_q <= off_q + 1'b1;
                end
            end else begin
                row_q <= row_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/corner_turn_ctrl.sv
module corner_turn_ctrl #(
    parameter int N_CHIRP = 64,
    parameter int N_RANGE = 256,
    parameter int SEG     = 16,
    parameter int DATA_W  = 32,
    localparam int OFS_W  = $clog2(N_CHIRP) + $clog2(N_RANGE / SEG) + $clog2(SEG),
    localparam int ADDR_W = OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_frame_end
);
    logic             wr_full, rd_idle, swap, wr_bank_q;
    logic [OFS_W-1:0] wr_ofs, rd_ofs;

    // roles exchange only when a full new frame meets a drained reader
    assign swap = wr_full && rd_idle;

    always_ff @(posedge clk) begin
        if (!rst_n)    wr_bank_q <= 1'b0;
        else if (swap) wr_bank_q <= ~wr_bank_q;
    end

    ct_writer #(.N_CHIRP(N_CHIRP), .N_RANGE(N_RANGE), .SEG(SEG)) u_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .swap     (swap),
        .in_ready (in_ready),
        .full     (wr_full),
        .wr_en    (mem_wr_en),
        .wr_ofs   (wr_ofs)
    );

    ct_reader #(.N_CHIRP(N_CHIRP), .N_RANGE(N_RANGE), .SEG(SEG)) u_reader (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (swap),
        .out_ready     (out_ready),
        .idle          (rd_idle),
        .rd_en         (mem_rd_en),
        .rd_ofs        (rd_ofs),
        .out_valid     (out_valid),
        .out_last      (out_last),
        .out_frame_end (out_frame_end)
    );

    assign mem_wr_addr = {wr_bank_q, wr_ofs};
    assign mem_rd_addr = {~wr_bank_q, rd_ofs};
    assign mem_wr_data = in_data;
    assign out_data    = mem_rd_data;
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic              out_frame_end
);
    p_bank_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_rd_en) |-> (mem_wr_addr[ADDR_W-1] != mem_rd_addr[ADDR_W-1]));

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_last) && $stable(out_frame_end)));

    p_end_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_frame_end) |-> out_last);

    p_gap_after_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_frame_end) |=> !out_valid);

    p_read_then_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> out_valid);

    p_read_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !out_valid);
endmodule

bind corner_turn_ctrl ct_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ct_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_wr_en     (mem_wr_en),
    .mem_wr_addr   (mem_wr_addr),
    .mem_rd_en     (mem_rd_en),
    .mem_rd_addr   (mem_rd_addr),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_last      (out_last),
    .out_frame_end (out_frame_end)
);

// File: tb/corner_turn_ctrl_bench.sv
module corner_turn_ctrl_bench;
    localparam int NC     = 8;
    localparam int NR     = 16;
    localparam int SG     = 4;
    localparam int DW     = 32;
    localparam int FRAMES = 6;
    localparam int TOTAL  = NC * NR;
    localparam int AW     = 1 + $clog2(TOTAL);
    localparam int LIMIT  = 20000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_ready;
    logic [DW-1:0] in_data;
    logic          mem_wr_en, mem_rd_en;
    logic [AW-1:0] mem_wr_addr, mem_rd_addr;
    logic [DW-1:0] mem_wr_data, mem_rd_data;
    logic          out_valid, out_ready, out_last, out_frame_end;
    logic [DW-1:0] out_data;

    always #10 clk = ~clk;

    corner_turn_ctrl #(.N_CHIRP(NC), .N_RANGE(NR), .SEG(SG), .DATA_W(DW)) u_corner_turn_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_frame_end(out_frame_end)
    );

    // behavioural two-bank memory, one-cycle read latency
    logic [DW-1:0] mem [0:2*TOTAL-1];
    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    end

    int checks = 0, fails = 0, cyc = 0;
    int wr_done = 0, wr_idx = 0, ra_done = 0, ra_idx = 0, rd_done = 0, rd_idx = 0;
    bit seen_out = 0, hold_pend = 0;
    logic [DW-1:0] hold_data;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tile_addr(input int f, input int r, input int c);
        return (f % 2) * TOTAL + ((c / SG) * NC + r) * SG + (c % SG);
    endfunction

    function automatic int sample(input int f, input int r, input int c);
        return f * 65536 + r * 1024 + c;
    endfunction

    // monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            // R7: writer stalls while holding frame k+1 and frame k is still draining
            if (wr_done >= rd_done + 2)
                check(!in_ready, "R7 in_ready during stall", in_ready, 0);
            // R8: held sample stays put
            if (hold_pend) begin
                check(out_valid && out_data == hold_data, "R8 hold data", out_data, hold_data);
                hold_pend = 0;
            end
            if (out_valid && !out_ready) begin
                hold_pend = 1;
                hold_data = out_data;
            end
            // R2, R9: write address and data
            if (mem_wr_en) begin
                check(int'(mem_wr_addr) == tile_addr(wr_done, wr_idx / NR, wr_idx % NR),
                      "R2/R9 write addr", mem_wr_addr, tile_addr(wr_done, wr_idx / NR, wr_idx % NR));
                check(mem_wr_data == in_data, "R2 write data", mem_wr_data, in_data);
                wr_idx++;
                if (wr_idx == TOTAL) begin wr_idx = 0; wr_done++; end
            end
            // R4, R9: read address walk
            if (mem_rd_en) begin
                check(int'(mem_rd_addr) == tile_addr(ra_done, ra_idx % NC, ra_idx / NC),
                      "R4/R9 read addr", mem_rd_addr, tile_addr(ra_done, ra_idx % NC, ra_idx / NC));
                ra_idx++;
                if (ra_idx == TOTAL) begin ra_idx = 0; ra_done++; end
            end
            // R5: first output only after a whole matrix is in
            if (out_valid && !seen_out) begin
                seen_out = 1;
                check(wr_done >= 1, "R5 first output after frame 0", wr_done, 1);
            end
            // R4, R6: data order and markers
            if (out_valid && out_ready) begin
                check(out_data == DW'(sample(rd_done, rd_idx % NC, rd_idx / NC)), "R4 out data",
                      out_data, sample(rd_done, rd_idx % NC, rd_idx / NC));
                check(out_last == ((rd_idx % NC) == NC - 1), "R6 out_last",
                      out_last, (rd_idx % NC) == NC - 1);
                check(out_frame_end == (rd_idx == TOTAL - 1), "R6 out_frame_end",
                      out_frame_end, rd_idx == TOTAL - 1);
                rd_idx++;
                if (rd_idx == TOTAL) begin rd_idx = 0; rd_done++; end
            end
        end
    end

    // downstream backpressure pattern with one long blocked window
    always @(posedge clk) begin
        #1;
        if (!rst_n) out_ready = 1'b1;
        else out_ready = !((cyc % 7) == 3) && !(cyc >= 500 && cyc < 800);
    end

    // source: back-to-back frames, odd frames with idle gaps
    initial begin
        in_valid = 1'b0;
        in_data  = '0;
        wait (rst_n === 1'b1);
        @(posedge clk); #1;
        for (int f = 0; f < FRAMES; f++) begin
            for (int r = 0; r < NC; r++) begin
                for (int c = 0; c < NR; c++) begin
                    if ((f % 2) == 1 && (c % 5) == 0) begin
                        in_valid = 1'b0;
                        @(posedge clk); #1;
                    end
                    in_valid = 1'b1;
                    in_data  = DW'(sample(f, r, c));
                    @(negedge clk);
                    while (!in_ready) @(negedge clk);
                    @(posedge clk); #1;
                end
            end
        end
        in_valid = 1'b0;
    end

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(!out_valid, "R1 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(in_ready, "R1 in_ready after reset", in_ready, 1);
        check(!out_valid, "R1 out_valid after reset", out_valid, 0);
        check(!mem_rd_en, "R1 mem_rd_en after reset", mem_rd_en, 0);
        while (rd_done < FRAMES && cyc < LIMIT) @(negedge clk);
        check(cyc < LIMIT, "watchdog", cyc, LIMIT);
        check(wr_done == FRAMES, "R9 frames written", wr_done, FRAMES);
        check(rd_done == FRAMES, "R4 frames read", rd_done, FRAMES);
        check(ra_done == FRAMES, "R10 frames fetched", ra_done, FRAMES);
        repeat (3) @(negedge clk);
        check(!out_valid && !mem_rd_en, "R7 idle after last frame", out_valid, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule